// File: doc/BRIEF.md
# Offset-QPSK Half-Sine Chip Shaper

This block turns a serial stream of spread-spectrum chips into two signed baseband sample streams, in-phase (I) and quadrature (Q), for offset QPSK with half-sine pulse shaping. Shaped this way, the signal is the same as MSK. Chips arrive at one chip every four clocks, with the clock running at the sample rate: 8 MS/s against 2 Mchip/s. Chips alternate between the two rails. Each chip starts a half-sine pulse that lasts two chip periods on its own rail.

Because a Q chip arrives one input chip period after the I chip before it, the Q rail trails the I rail by half of a rail pulse. A start marker that comes with a chip begins a new frame. That chip goes to I, and the Q rail is silenced until the next chip. When the chips stop, every pulse in flight runs to its end and the rails then fall to zero.

Top module: `oqpsk_shaper`

## Requirements
- R1: After reset, `i_sample` and `q_sample` are 0 and `sample_vld` is 0.
- R2: A chip of value 1 produces, on its rail, eight samples starting the cycle after the strobe: 25, 71, 106, 125, 125, 106, 71, 25. Each sample is round(127·sin(π(n+0.5)/8)) for n = 0..7.
- R3: A chip of value 0 produces the same eight magnitudes with a negative sign.
- R4: Chips alternate between rails: the 1st, 3rd, 5th... chip after a start goes to I (rail 0), and the 2nd, 4th... go to Q (rail 1).
- R5: After a strobe that carries the start marker, `q_sample` is 0 for one chip period (four samples) before the next chip's Q pulse begins.
- R6: A strobe with the start marker sends its chip to I whatever the previous parity was, and ends any Q pulse still in flight.
- R7: With no further chips, each rail finishes its current pulse and then outputs 0.
- R8: `sample_vld` is 1 exactly while at least one rail is inside a pulse; when it is 0, both samples are 0.
- R9: In a continuous stream, the pulses on each rail abut with no gap: the last sample of one pulse is followed at once by the first sample of the next.
- R10: The start marker without a chip strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (8 MS/s) |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_stb | input | 1 | A chip is present this cycle |
| chip_bit | input | 1 | Chip value, qualified by `chip_stb` |
| chip_start | input | 1 | First chip of a frame, qualified by `chip_stb` |
| i_sample | output | 8 | Signed in-phase sample |
| q_sample | output | 8 | Signed quadrature sample |
| sample_vld | output | 1 | A rail is mid-pulse |

## Verification
The bench builds an expected waveform for each rail directly from the chip timing. It checks that waveform sample by sample, including cycles where nothing is happening. A mid-frame restart is placed while a Q pulse is half done. A router that did not reset parity would send that chip to Q, and a rail that was not cleared would leave a truncated tail on `q_sample`. A lone start marker between chips would flip the alternation if it were not gated by the strobe. At end of stream, a design that cut pulses short or let the phase wrap would show the wrong length or a repeated pulse. Back-to-back chips expose an off-by-one in the pulse length, which would show as gaps or overlaps on each rail.

// File: rtl/oqpsk_pkg.sv
package oqpsk_pkg;
  localparam int SAMP_W    = 8;
  localparam int SPC       = 4;            // samples per input chip
  localparam int PULSE_LEN = 2 * SPC;      // one pulse spans two chips
  localparam int PH_W      = $clog2(PULSE_LEN);
  localparam int NUM_RAILS = 2;

  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef enum logic {RAIL_I = 1'b0, RAIL_Q = 1'b1} rail_e;

  // Half-sine at mid-sample points, amplitude 127.
  function automatic samp_t half_sine(input logic [PH_W-1:0] ph, input logic pos);
    samp_t mag;
    case (ph)
      3'd0, 3'd7: mag = 8'sd25;
      3'd1, 3'd6: mag = 8'sd71;
      3'd2, 3'd5: mag = 8'sd106;
      default:    mag = 8'sd125;
    endcase
    return pos ? mag : -mag;
  endfunction
endpackage

// File: rtl/chip_router.sv
module chip_router
  import oqpsk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chip_stb,
  input  logic                 chip_start,
  output logic [NUM_RAILS-1:0] rail_load,
  output logic [NUM_RAILS-1:0] rail_clear
);
  logic  odd_q;
  rail_e sel;

  assign sel = (chip_start || !odd_q) ? RAIL_I : RAIL_Q;

  always_comb begin
    rail_load  = '0;
    rail_clear = '0;
    if (chip_stb) begin
      rail_load[sel] = 1'b1;
      if (chip_start) rail_clear[RAIL_Q] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        odd_q <= 1'b0;
    else if (chip_stb) odd_q <= (sel == RAIL_I);
  end
endmodule

// File: rtl/pulse_rail.sv
module pulse_rail
  import oqpsk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  clear,
  input  logic  bit_in,
  output samp_t samp,
  output logic  active
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PULSE_LEN - 1);

  logic [PH_W-1:0] ph;
  logic            pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      pos    <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      ph     <= '0;
      pos    <= bit_in;
    end else if (clear) begin
      active <= 1'b0;
      ph     <= '0;
    end else if (active) begin
      if (ph == LAST_PH) active <= 1'b0;
      ph <= ph + 1'b1;
    end
  end

  assign samp = active ? half_sine(ph, pos) : '0;
endmodule

// File: rtl/oqpsk_shaper.sv
module oqpsk_shaper
  import oqpsk_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chip_stb,
  input  logic                     chip_bit,
  input  logic                     chip_start,
  output logic signed [SAMP_W-1:0] i_sample,
  output logic signed [SAMP_W-1:0] q_sample,
  output logic                     sample_vld
);
  logic [NUM_RAILS-1:0] rail_load;
  logic [NUM_RAILS-1:0] rail_clear;
  logic [NUM_RAILS-1:0] rail_act;
  samp_t                rail_samp [NUM_RAILS];

  chip_router u_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_stb   (chip_stb),
    .chip_start (chip_start),
    .rail_load  (rail_load),
    .rail_clear (rail_clear)
  );

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    pulse_rail u_rail (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (rail_load[r]),
      .clear  (rail_clear[r]),
      .bit_in (chip_bit),
      .samp   (rail_samp[r]),
      .active (rail_act[r])
    );
  end

  assign i_sample   = rail_samp[RAIL_I];
  assign q_sample   = rail_samp[RAIL_Q];
  assign sample_vld = |rail_act;
endmodule

// File: rtl/oqpsk_shaper_checker.sv
module oqpsk_shaper_checker (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_stb,
  input logic              chip_bit,
  input logic              chip_start,
  input logic [1:0]        rail_load,
  input logic [1:0]        rail_clear,
  input logic signed [7:0] i_sample,
  input logic signed [7:0] q_sample,
  input logic              sample_vld
);
  logic last_was_i;
  always_ff @(posedge clk) begin
    if (!rst_n)            last_was_i <= 1'b0;
    else if (rail_load[0]) last_was_i <= 1'b1;
    else if (rail_load[1]) last_was_i <= 1'b0;
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rail_load)); // R4
  AST_ALT_TO_Q: assert property (@(posedge clk) disable iff (!rst_n) chip_stb && !chip_start && last_was_i |-> rail_load[1]); // R4
  AST_ALT_TO_I: assert property (@(posedge clk) disable iff (!rst_n) chip_stb && !last_was_i |-> rail_load[0]); // R4
  AST_START_TO_I: assert property (@(posedge clk) disable iff (!rst_n) chip_stb && chip_start |-> rail_load[0]); // R6
  AST_CLEAR_Q_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n) rail_clear[1] |-> chip_start && chip_stb); // R6
  AST_I_NEVER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) !rail_clear[0]); // R6
  AST_FIRST_POS: assert property (@(posedge clk) disable iff (!rst_n) rail_load[0] && chip_bit |=> i_sample == 8'sd25); // R2
  AST_FIRST_NEG: assert property (@(posedge clk) disable iff (!rst_n) rail_load[0] && !chip_bit |=> i_sample == -8'sd25); // R3
  AST_Q_LEADIN: assert property (@(posedge clk) disable iff (!rst_n) chip_stb && chip_start |=> q_sample == 8'sd0); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !sample_vld |-> i_sample == 8'sd0 && q_sample == 8'sd0); // R8
  AST_NO_STB_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !chip_stb |-> rail_load == 2'b00); // R10
endmodule

bind oqpsk_shaper oqpsk_shaper_checker u_chk (.*);

// File: tb/oqpsk_shaper_test.sv
module oqpsk_shaper_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 32;
  localparam int MAXL = 4 * MAXC + 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_stb = 1'b0, chip_bit = 1'b0, chip_start = 1'b0;
  logic signed [7:0] i_sample, q_sample;
  logic sample_vld;

  int checks = 0, fails = 0;
  bit cbit [MAXC];
  bit cst  [MAXC];
  int ei [MAXL], eq [MAXL];
  bit ev [MAXL];

  always #(CLK_PERIOD/2) clk = ~clk;

  oqpsk_shaper uut (.*);

  function automatic int shape(int j);
    return $rtoi(127.0 * $sin(3.14159265358979 * (j + 0.5) / 8.0) + 0.5);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Chip k is sampled at posedge 4k; stray_start pulses start alone at that posedge.
  task automatic run_stream(string req, int n, int stray_start);
    int par = 0;
    bit qa [MAXL];
    bit ia [MAXL];
    int len = 4 * n + 12;
    for (int p = 0; p < MAXL; p++) begin ei[p] = 0; eq[p] = 0; ia[p] = 0; qa[p] = 0; end
    for (int k = 0; k < n; k++) begin
      int s = 4 * k;
      bit to_i = cst[k] || (par == 0);
      if (cst[k])
        for (int p = s; p < MAXL; p++) begin eq[p] = 0; qa[p] = 0; end
      for (int j = 0; j < 8; j++) begin
        int v = cbit[k] ? shape(j) : -shape(j);
        if (to_i) begin ei[s+j] = v; ia[s+j] = 1; end
        else      begin eq[s+j] = v; qa[s+j] = 1; end
      end
      par = to_i ? 1 : 0;
    end
    for (int p = 0; p < MAXL; p++) ev[p] = ia[p] | qa[p];
    for (int p = 0; p < len; p++) begin
      chip_stb   = (p % 4 == 0) && (p / 4 < n);
      chip_bit   = chip_stb ? cbit[p/4] : 1'b0;
      chip_start = (chip_stb && cst[p/4]) || (p == stray_start);
      @(posedge clk);
      @(negedge clk);
      chip_stb = 1'b0; chip_bit = 1'b0; chip_start = 1'b0;
      check(req, $sformatf("i_sample @%0d", p), i_sample, ei[p]);
      check(req, $sformatf("q_sample @%0d", p), q_sample, eq[p]);
      check(req, $sformatf("sample_vld @%0d", p), sample_vld, ev[p]);
    end
  endtask

  task automatic t_reset;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R1", "i_sample", i_sample, 0);
      check("R1", "q_sample", q_sample, 0);
      check("R1", "sample_vld", sample_vld, 0);
    end
  endtask

  task automatic t_single_one;   // R2 R7 R8
    cbit[0] = 1; cst[0] = 1;
    run_stream("R2", 1, -1);
  endtask

  task automatic t_single_zero;  // R3 R7
    cbit[0] = 0; cst[0] = 1;
    run_stream("R3", 1, -1);
  endtask

  task automatic t_pair;         // R4 R5
    cbit[0] = 1; cst[0] = 1; cbit[1] = 0; cst[1] = 0;
    run_stream("R5", 2, -1);
  endtask

  task automatic t_continuous;   // R9 R4
    for (int k = 0; k < 16; k++) begin cbit[k] = ((k * 7 + 3) % 5) > 1; cst[k] = (k == 0); end
    run_stream("R9", 16, -1);
  endtask

  task automatic t_resync;       // R6: restart while Q pulse half done
    cbit[0] = 1; cst[0] = 1; cbit[1] = 1; cst[1] = 0;
    cbit[2] = 0; cst[2] = 1; cbit[3] = 1; cst[3] = 0;
    run_stream("R6", 4, -1);
  endtask

  task automatic t_stray_start;  // R10
    for (int k = 0; k < 5; k++) begin cbit[k] = k[0]; cst[k] = (k == 0); end
    run_stream("R10", 5, 6);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_single_one();
    t_single_zero();
    t_pair();
    t_continuous();
    t_resync();
    t_stray_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule